// File: doc/BRIEF.md
# Dual-Bank Status Calendar Configuration Registers

This block is the control and status register file for the transmit status-calendar logic of a packet-over-PHY link interface. A host reaches it over a simple register bus with a 4-bit address, separate read and write strobes, 16-bit write data and registered read data. The register file holds a fixed identification word, a handful of control bits, and two banks of calendar settings. Each bank has a multiplier, a length and a calendar RAM. This lets a new calendar be prepared in the idle bank while the other bank drives the status frames.

Each bank's calendar RAM (1024 words of 8 bits) is reached only indirectly. An address register selects the word. A write to a bank's data register stores into that bank's RAM. A read from it fetches the selected word into the read register. Writes to a bank are refused while the status logic is using that bank, unless the status logic reports itself disabled. Refused writes, and writes to read-only or reserved locations, are dropped and raise a sticky error flag. The block also drives the effective status-frame reset: its own reset bit ORed with an external control input. The status-frame machine that acts on that reset runs elsewhere. It lowers sync and raises disabled at the end of the frame in progress, and it returns to normal operation once the reset is removed.

Register map: 0 identification (bits 15:13 block number, 12:0 type code); 1 control/status; 2 bank-0 multiplier; 3 bank-1 multiplier; 4 bank-0 length; 5 bank-1 length; 6 RAM address; 7 bank-0 RAM data; 8 bank-1 RAM data; 9 to 15 reserved. Register 1 holds the following bits: bit 0 hitless-repositioning enable (rw); bit 1 frame-reset bit (rw); bit 4 active bank (ro); bit 5 sync mirror (ro); bit 6 disabled mirror (ro); bit 15 sticky error (ro, cleared by writing 1).

Top module: `cal_cfg_regfile`

## Requirements
- R1: A read of address 0 returns the block number in bits 15:13 and the 13-bit type code in bits 12:0. A write there changes nothing and sets the error flag.
- R2: Synchronous active-high reset clears every control register, the RAM address, the error flag and the read register, and sets the frame-reset bit (register 1 bit 1) to 1.
- R3: The frame_rst_eff output is high whenever register 1 bit 1 is set or ext_frame_rst is high, and low otherwise.
- R4: A read of register 1 returns sts_active_bank in bit 4 (0 means select word 2'b01 is in use, 1 means 2'b10), sts_sync in bit 5 and sts_disabled in bit 6, sampled in the read cycle.
- R5: While register 1 bit 0 (hitless enable) is 0, registers 3, 5 and 8 read as zero, and writes to them are dropped and set the error flag.
- R6: Writes to registers 2, 4 and 7 take effect only when sts_disabled is 1 or sts_active_bank is 1. Otherwise they are dropped and set the error flag.
- R7: Writes to registers 3, 5 and 8 take effect only when hitless enable is 1 and either sts_disabled is 1 or sts_active_bank is 0. Otherwise they are dropped and set the error flag.
- R8: An accepted write to register 7 or 8 stores the low 8 data bits into that bank's RAM at the word held in register 6.
- R9: A read of register 7 or 8 returns that bank's RAM word at the address in register 6, zero-extended.
- R10: bus_rdata changes only at the clock edge that samples a read strobe, holding its value otherwise. Reserved addresses read as zero.
- R11: The error flag (register 1 bit 15) stays set until a write to register 1 with bit 15 high clears it. Writes to addresses 9 to 15 also set it.
- R12: When read and write strobes hit the same address in one cycle, the read returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after bus_rd |
| ext_frame_rst | input | 1 | External status-frame reset request |
| sts_sync | input | 1 | Sync status from the status-frame machine |
| sts_disabled | input | 1 | Disabled status from the status-frame machine |
| sts_active_bank | input | 1 | Calendar bank currently in use |
| frame_rst_eff | output | 1 | Effective status-frame reset |
| hitless_en | output | 1 | Hitless repositioning enable |
| bank0_mult | output | 8 | Bank 0 calendar multiplier |
| bank0_len | output | 10 | Bank 0 calendar length |
| bank1_mult | output | 8 | Bank 1 calendar multiplier |
| bank1_len | output | 10 | Bank 1 calendar length |

## Verification
A single bus cycle can carry a read and a write to the same register. The value returned must then be the pre-write one, while the write and its protection check still apply in that cycle. The bench raises both strobes together in directed cases and in a share of its random operations. It predicts the read from its model before applying the write to that model. The bank-status inputs are also changed at random between operations, so the protection decision is judged against the status seen in the very cycle of the write.

// File: rtl/cal_cfg_pkg.sv
package cal_cfg_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 4;
  localparam int NREG   = 1 << ADDR_W;
  localparam int NBANK  = 2;

  localparam logic [ADDR_W-1:0] A_ID    = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MULT0 = 4'd2;
  localparam logic [ADDR_W-1:0] A_MULT1 = 4'd3;
  localparam logic [ADDR_W-1:0] A_LEN0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_LEN1  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RADDR = 4'd6;
  localparam logic [ADDR_W-1:0] A_DAT0  = 4'd7;
  localparam logic [ADDR_W-1:0] A_DAT1  = 4'd8;

  localparam int B_HITLESS = 0;
  localparam int B_FRST    = 1;
  localparam int B_ACTIVE  = 4;
  localparam int B_SYNC    = 5;
  localparam int B_DIS     = 6;
  localparam int B_ERR     = 15;
endpackage

// File: rtl/cal_wr_guard.sv
module cal_wr_guard
  import cal_cfg_pkg::*;
(
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hitless,
  input  logic              sts_disabled,
  input  logic              sts_active_bank,
  output logic [NREG-1:0]   we,
  output logic              blocked
);
  logic bank0_ok, bank1_ok, ok;

  assign bank0_ok = sts_disabled | sts_active_bank;
  assign bank1_ok = hitless & (sts_disabled | ~sts_active_bank);

  always_comb begin
    unique case (addr)
      A_CTRL, A_RADDR:         ok = 1'b1;
      A_MULT0, A_LEN0, A_DAT0: ok = bank0_ok;
      A_MULT1, A_LEN1, A_DAT1: ok = bank1_ok;
      default:                 ok = 1'b0;
    endcase
  end

  always_comb begin
    we = '0;
    if (wr && ok) we[addr] = 1'b1;
  end

  assign blocked = wr & ~ok;
endmodule

// File: rtl/cal_bank_store.sv
module cal_bank_store #(
  parameter int MULT_W = 8,
  parameter int LEN_W  = 10,
  parameter int RAM_AW = 10,
  parameter int RAM_DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mult,
  input  logic              wr_len,
  input  logic              wr_ram,
  input  logic [MULT_W-1:0] mult_d,
  input  logic [LEN_W-1:0]  len_d,
  input  logic [RAM_DW-1:0] ram_d,
  input  logic [RAM_AW-1:0] ram_addr,
  output logic [MULT_W-1:0] mult_q,
  output logic [LEN_W-1:0]  len_q,
  output logic [RAM_DW-1:0] ram_q
);
  localparam int DEPTH = 1 << RAM_AW;

  logic [RAM_DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q <= '0;
      len_q  <= '0;
    end else begin
      if (wr_mult) mult_q <= mult_d;
      if (wr_len)  len_q  <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ram) mem[ram_addr] <= ram_d;
  end

  assign ram_q = mem[ram_addr];
endmodule

// File: rtl/cal_cfg_regfile.sv
module cal_cfg_regfile
  import cal_cfg_pkg::*;
#(
  parameter int          MULT_W    = 8,
  parameter int          LEN_W     = 10,
  parameter int          RAM_AW    = 10,
  parameter int          RAM_DW    = 8,
  parameter logic [12:0] TYPE_CODE = 13'h0A5C,
  parameter logic [2:0]  BLOCK_ID  = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_frame_rst,
  input  logic              sts_sync,
  input  logic              sts_disabled,
  input  logic              sts_active_bank,
  output logic              frame_rst_eff,
  output logic              hitless_en,
  output logic [MULT_W-1:0] bank0_mult,
  output logic [LEN_W-1:0]  bank0_len,
  output logic [MULT_W-1:0] bank1_mult,
  output logic [LEN_W-1:0]  bank1_len
);
  logic              hitless_q, frst_q, err_q;
  logic [RAM_AW-1:0] raddr_q;
  logic [NREG-1:0]   we;
  logic              blocked;
  logic [MULT_W-1:0] mult_arr [NBANK];
  logic [LEN_W-1:0]  len_arr  [NBANK];
  logic [RAM_DW-1:0] ram_arr  [NBANK];
  logic [BUS_W-1:0]  rd_val;
  logic              unused_wdata_ok;

  assign unused_wdata_ok = ^bus_wdata;

  cal_wr_guard u_guard (
    .wr              (bus_wr),
    .addr            (bus_addr),
    .hitless         (hitless_q),
    .sts_disabled    (sts_disabled),
    .sts_active_bank (sts_active_bank),
    .we              (we),
    .blocked         (blocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hitless_q <= 1'b0;
      frst_q    <= 1'b1;
      err_q     <= 1'b0;
      raddr_q   <= '0;
    end else begin
      if (we[A_CTRL]) begin
        hitless_q <= bus_wdata[B_HITLESS];
        frst_q    <= bus_wdata[B_FRST];
      end
      if (blocked)                              err_q <= 1'b1;
      else if (we[A_CTRL] && bus_wdata[B_ERR])  err_q <= 1'b0;
      if (we[A_RADDR]) raddr_q <= bus_wdata[RAM_AW-1:0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cal_bank_store #(
      .MULT_W (MULT_W),
      .LEN_W  (LEN_W),
      .RAM_AW (RAM_AW),
      .RAM_DW (RAM_DW)
    ) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_mult  (we[int'(A_MULT0) + b]),
      .wr_len   (we[int'(A_LEN0) + b]),
      .wr_ram   (we[int'(A_DAT0) + b]),
      .mult_d   (bus_wdata[MULT_W-1:0]),
      .len_d    (bus_wdata[LEN_W-1:0]),
      .ram_d    (bus_wdata[RAM_DW-1:0]),
      .ram_addr (raddr_q),
      .mult_q   (mult_arr[b]),
      .len_q    (len_arr[b]),
      .ram_q    (ram_arr[b])
    );
  end

  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      A_ID:    rd_val = {BLOCK_ID, TYPE_CODE};
      A_CTRL: begin
        rd_val[B_HITLESS] = hitless_q;
        rd_val[B_FRST]    = frst_q;
        rd_val[B_ACTIVE]  = sts_active_bank;
        rd_val[B_SYNC]    = sts_sync;
        rd_val[B_DIS]     = sts_disabled;
        rd_val[B_ERR]     = err_q;
      end
      A_MULT0: rd_val = BUS_W'(mult_arr[0]);
      A_LEN0:  rd_val = BUS_W'(len_arr[0]);
      A_DAT0:  rd_val = BUS_W'(ram_arr[0]);
      A_MULT1: rd_val = hitless_q ? BUS_W'(mult_arr[1]) : '0;
      A_LEN1:  rd_val = hitless_q ? BUS_W'(len_arr[1])  : '0;
      A_DAT1:  rd_val = hitless_q ? BUS_W'(ram_arr[1])  : '0;
      A_RADDR: rd_val = BUS_W'(raddr_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  assign frame_rst_eff = frst_q | ext_frame_rst;
  assign hitless_en    = hitless_q;
  assign bank0_mult    = mult_arr[0];
  assign bank0_len     = len_arr[0];
  assign bank1_mult    = mult_arr[1];
  assign bank1_len     = len_arr[1];
endmodule

// File: rtl/cal_cfg_regfile_chk.sv
module cal_cfg_regfile_chk
  import cal_cfg_pkg::*;
#(
  parameter int          MULT_W    = 8,
  parameter int          LEN_W     = 10,
  parameter logic [12:0] TYPE_CODE = 13'h0A5C,
  parameter logic [2:0]  BLOCK_ID  = 3'd5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              ext_frame_rst,
  input logic              frame_rst_eff,
  input logic              sts_disabled,
  input logic              sts_active_bank,
  input logic              hitless_en,
  input logic [MULT_W-1:0] bank0_mult,
  input logic [MULT_W-1:0] bank1_mult,
  input logic [LEN_W-1:0]  bank1_len,
  input logic              err_q
);
  p_id_read_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_ID) |=> (bus_rdata == {BLOCK_ID, TYPE_CODE}));

  p_ext_frame_rst_r3: assert property (@(posedge clk) disable iff (rst)
    ext_frame_rst |-> frame_rst_eff);

  p_hitless_off_len1_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_LEN1 && !hitless_en) |=> ($stable(bank1_len) && err_q));

  p_bank0_guard_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MULT0 && !sts_disabled && !sts_active_bank)
      |=> ($stable(bank0_mult) && err_q));

  p_bank1_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MULT1 && !sts_disabled && sts_active_bank)
      |=> ($stable(bank1_mult) && err_q));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(bus_wr && bus_addr == A_CTRL && bus_wdata[B_ERR])) |=> err_q);

  p_reserved_err_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr > A_DAT1) |=> err_q);
endmodule

bind cal_cfg_regfile cal_cfg_regfile_chk #(
  .MULT_W    (MULT_W),
  .LEN_W     (LEN_W),
  .TYPE_CODE (TYPE_CODE),
  .BLOCK_ID  (BLOCK_ID)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .bus_addr        (bus_addr),
  .bus_rd          (bus_rd),
  .bus_wr          (bus_wr),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .ext_frame_rst   (ext_frame_rst),
  .frame_rst_eff   (frame_rst_eff),
  .sts_disabled    (sts_disabled),
  .sts_active_bank (sts_active_bank),
  .hitless_en      (hitless_en),
  .bank0_mult      (bank0_mult),
  .bank1_mult      (bank1_mult),
  .bank1_len       (bank1_len),
  .err_q           (err_q)
);

// File: tb/cal_cfg_regfile_test.sv
`timescale 1ns/1ps
module cal_cfg_regfile_test;
  localparam logic [12:0] TCODE = 13'h0A5C;
  localparam logic [2:0]  BID   = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_frame_rst = 1'b0, sts_sync = 1'b0;
  logic        sts_disabled = 1'b0, sts_active_bank = 1'b0;
  logic        frame_rst_eff, hitless_en;
  logic [7:0]  bank0_mult, bank1_mult;
  logic [9:0]  bank0_len, bank1_len;

  always #5 clk = ~clk;

  cal_cfg_regfile #(.TYPE_CODE(TCODE), .BLOCK_ID(BID)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_frame_rst(ext_frame_rst),
    .sts_sync(sts_sync), .sts_disabled(sts_disabled), .sts_active_bank(sts_active_bank),
    .frame_rst_eff(frame_rst_eff), .hitless_en(hitless_en),
    .bank0_mult(bank0_mult), .bank0_len(bank0_len),
    .bank1_mult(bank1_mult), .bank1_len(bank1_len)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  bit          m_hit, m_frs, m_err;
  logic [7:0]  m_mult [2];
  logic [9:0]  m_len  [2];
  logic [9:0]  m_ra;
  logic [7:0]  m_ram  [2][1024];
  logic [15:0] m_rdata;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit bank_ok(input int b);
    if (b == 0) return sts_disabled | sts_active_bank;
    return m_hit & (sts_disabled | ~sts_active_bank);
  endfunction

  function automatic bit wr_ok(input logic [3:0] a);
    case (a)
      4'd1, 4'd6:       return 1'b1;
      4'd2, 4'd4, 4'd7: return bank_ok(0);
      4'd3, 4'd5, 4'd8: return bank_ok(1);
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return {BID, TCODE};
      4'd1: return {m_err, 8'b0, sts_disabled, sts_sync, sts_active_bank, 2'b0, m_frs, m_hit};
      4'd2: return {8'b0, m_mult[0]};
      4'd3: return m_hit ? {8'b0, m_mult[1]} : 16'h0;
      4'd4: return {6'b0, m_len[0]};
      4'd5: return m_hit ? {6'b0, m_len[1]} : 16'h0;
      4'd6: return {6'b0, m_ra};
      4'd7: return {8'b0, m_ram[0][m_ra]};
      4'd8: return m_hit ? {8'b0, m_ram[1][m_ra]} : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [15:0] d);
    if (!wr_ok(a)) begin m_err = 1'b1; return; end
    case (a)
      4'd1: begin m_hit = d[0]; m_frs = d[1]; if (d[15]) m_err = 1'b0; end
      4'd2: m_mult[0] = d[7:0];
      4'd3: m_mult[1] = d[7:0];
      4'd4: m_len[0] = d[9:0];
      4'd5: m_len[1] = d[9:0];
      4'd6: m_ra = d[9:0];
      4'd7: m_ram[0][m_ra] = d[7:0];
      4'd8: m_ram[1][m_ra] = d[7:0];
      default: ;
    endcase
  endtask

  // One bus cycle; read value predicted before the write is applied (R12).
  task automatic op(input logic [3:0] a, input bit rd, input bit wr,
                    input logic [15:0] d, input string tag);
    logic [15:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d;
    e = exp_rd(a);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    if (rd) m_rdata = e;
    if (wr) model_wr(a, d);
    check({tag, " rdata R10"}, 32'(bus_rdata), 32'(m_rdata));
    check("R3 frame_rst_eff", 32'(frame_rst_eff), 32'(m_frs | ext_frame_rst));
    check("R5 hitless_en", 32'(hitless_en), 32'(m_hit));
    check("R6 bank0", {4'b0, bank0_len, bank0_mult, 10'b0}, {4'b0, m_len[0], m_mult[0], 10'b0});
    check("R7 bank1", {4'b0, bank1_len, bank1_mult, 10'b0}, {4'b0, m_len[1], m_mult[1], 10'b0});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd77));
    m_hit = 0; m_frs = 1; m_err = 0; m_ra = '0; m_rdata = '0;
    for (int b = 0; b < 2; b++) begin m_mult[b] = '0; m_len[b] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R2 reset rdata", 32'(bus_rdata), 32'h0);
    check("R2 reset frame_rst_eff", 32'(frame_rst_eff), 32'h1);
    op(4'd1, 1, 0, 16'h0, "R2 ctrl after reset");
    check("R2 ctrl value", 32'(bus_rdata), 32'h0002);

    // R3: clear own bit, then drive external request
    op(4'd1, 0, 1, 16'h0001, "R3 clear bit");
    check("R3 eff low", 32'(frame_rst_eff), 32'h0);
    ext_frame_rst = 1'b1; #1;
    check("R3 ext high", 32'(frame_rst_eff), 32'h1);
    ext_frame_rst = 1'b0;

    // R1 + R11
    op(4'd0, 1, 0, 16'h0, "R1 id read");
    check("R1 id value", 32'(bus_rdata), {16'h0, BID, TCODE});
    op(4'd0, 0, 1, 16'hFFFF, "R1 id write");
    op(4'd1, 1, 0, 16'h0, "R11 err set");
    check("R11 err bit", 32'(bus_rdata[15]), 32'h1);
    op(4'd0, 1, 0, 16'h0, "R1 id unchanged");
    op(4'd1, 0, 1, 16'h8001, "R11 clear");
    op(4'd1, 1, 0, 16'h0, "R11 err cleared");
    check("R11 err clear", 32'(bus_rdata[15]), 32'h0);
    op(4'd12, 0, 1, 16'h1234, "R11 reserved write");
    op(4'd12, 1, 0, 16'h0, "R10 reserved read");
    check("R10 reserved zero", 32'(bus_rdata), 32'h0);
    op(4'd1, 1, 0, 16'h0, "R11 err reserved");
    check("R11 reserved err", 32'(bus_rdata[15]), 32'h1);
    op(4'd1, 0, 1, 16'h8001, "R11 clear2");

    // R4
    sts_sync = 1; sts_disabled = 0; sts_active_bank = 1;
    op(4'd1, 1, 0, 16'h0, "R4 status");
    check("R4 status bits", 32'(bus_rdata), 32'h0031);

    // R6/R7 with active bank 1: bank0 open, bank1 closed
    op(4'd2, 0, 1, 16'h00A1, "R6 bank0 open");
    op(4'd3, 0, 1, 16'h00B2, "R7 bank1 closed");
    check("R7 blocked mult1", 32'(bank1_mult), 32'h0);
    sts_active_bank = 0;
    op(4'd4, 0, 1, 16'h0155, "R6 bank0 closed");
    check("R6 blocked len0", 32'(bank0_len), 32'h0);
    op(4'd5, 0, 1, 16'h02AA, "R7 bank1 open");
    check("R7 len1 written", 32'(bank1_len), 32'h02AA);

    // R5: hitless off
    op(4'd1, 0, 1, 16'h8000, "R5 hitless off");
    sts_disabled = 1;
    op(4'd5, 0, 1, 16'h0011, "R5 len1 write dropped");
    op(4'd5, 1, 0, 16'h0, "R5 len1 reads zero");
    check("R5 len1 zero", 32'(bus_rdata), 32'h0);
    check("R5 len1 kept", 32'(bank1_len), 32'h02AA);
    op(4'd1, 0, 1, 16'h8001, "R5 hitless on");

    // R8/R9: fill both RAMs
    for (int i = 0; i < 1024; i++) begin
      op(4'd6, 0, 1, 16'(i), "R8 addr");
      op(4'd7, 0, 1, 16'((i * 7 + 3) & 8'hFF), "R8 ram0");
      op(4'd8, 0, 1, 16'((i * 13 + 91) & 8'hFF), "R8 ram1");
    end
    op(4'd6, 0, 1, 16'd517, "R9 addr");
    op(4'd7, 1, 0, 16'h0, "R9 ram0");
    check("R9 ram0 word", 32'(bus_rdata), 32'((517 * 7 + 3) & 8'hFF));
    op(4'd8, 1, 0, 16'h0, "R9 ram1");
    check("R9 ram1 word", 32'(bus_rdata), 32'((517 * 13 + 91) & 8'hFF));

    // R12: read and write same register same cycle
    op(4'd2, 1, 1, 16'h005A, "R12 mult0 rd+wr");
    check("R12 old mult0", 32'(bus_rdata), 32'h00A1);
    op(4'd7, 1, 1, 16'h00EE, "R12 ram0 rd+wr");
    check("R12 old ram0", 32'(bus_rdata), 32'((517 * 7 + 3) & 8'hFF));

    // R10 hold
    op(4'd2, 0, 0, 16'h0, "R10 hold");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic [3:0]  a;
      logic [15:0] d;
      int          k;
      if (($urandom % 8) == 0) begin
        sts_disabled    = ($urandom % 4) == 0;
        sts_active_bank = $urandom % 2;
        sts_sync        = $urandom % 2;
        ext_frame_rst   = ($urandom % 5) == 0;
      end
      a = 4'($urandom % 16);
      d = 16'($urandom);
      if (a == 4'd1) d[0] = ($urandom % 6) != 0;
      k = $urandom % 4;
      op(a, k != 1, k != 0, d, "RND R6 R7 R12");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule